// File: doc/BRIEF.md
# GPIO Function-Select and Level Controller

This block is a register-mapped controller for 54 general-purpose pins. Software programs a 3-bit function code for every pin, raises and lowers a latched level per pin through separate write-only set and clear ports, reads the latched levels back, and keeps four pull-configuration words. Each pin presents a drive value and an output-enable. The output-enable is high only while the pin is in output mode.

A small selector also decides which of two host controllers owns an attached card interface. It looks at the function codes of pins 48 to 53. It moves to controller B when all six pins are in alt0 mode, and back to controller A when all six are inputs. Any other combination leaves the previous choice in place, so a half-finished reprogramming sequence never bounces the card between hosts.

The bus is a simple single-cycle word interface. Writes take effect on the clock edge that samples them. Read data and the error flag appear one cycle after the request.

Top module: `gfl_pin_ctrl`

## Requirements
- R1: Pin p owns a 3-bit function field at bits [3*(p%10)+2 : 3*(p%10)] of function word floor(p/10), at byte offset 4*floor(p/10) (0x00 to 0x14). Bits 31:30 of every function word, and fields that belong to pin numbers 54 and above, are discarded on write and read back as zero.
- R2: pin_oe[p] is 1 exactly while pin p holds function code 1 (output). Code 0 is input, code 4 is alt0, and codes 2, 3, 5, 6 and 7 are further alternate modes.
- R3: A write to 0x1C ORs bit p of the data into the level latch of pin p (pins 0 to 31). A write to 0x20 does the same with bit p-32 for pins 32 to 53. Writes to 0x28 and 0x2C clear the latched levels of the pins whose bits are set, using the same layout. Reads of 0x34 and 0x38 return the latches in the same layout, and bits 31:22 of 0x38 read zero.
- R4: Reads of the four set and clear offsets return zero.
- R5: Writes to the level offsets 0x34 and 0x38 change nothing and raise no error.
- R6: pin_drive[p] takes a pin's new latched level only when that pin holds code 1 at the time of the write and the set or clear write actually changes its latch. Otherwise pin_drive[p] holds. The latch itself updates in every mode.
- R7: The four pull words at 0xE4, 0xE8, 0xEC and 0xF0 are fully read/write. They reset to 0xAAA95555, 0xA0AAAAAA, 0x50AAA95A and 0x00055555 respectively.
- R8: card_route_b becomes 1 when pins 48 to 53 all hold code 4 (alt0). It becomes 0 when they all hold code 0. Any other mix holds it. It updates on the clock edge after the edge that stores the function write.
- R9: Word-aligned offsets from 0x40 through 0x8C read zero, ignore writes and raise no error.
- R10: Any other offset, and any address that is not a multiple of 4, reads zero and ignores writes. bus_err is high for exactly the one cycle after such an access.
- R11: bus_rdata carries the addressed word in the cycle after bus_rd is sampled. It is zero in every cycle that does not follow a read.
- R12: After reset, all function codes are 0, all latches and drive values are 0, pin_oe is 0, card_route_b is 0 (controller A), and bus_rdata and bus_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW (8) | Byte offset of the access |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, one cycle after the read |
| bus_err | output | 1 | One-cycle flag for an unmapped access |
| pin_drive | output | NUM_PINS (54) | Per-pin drive value |
| pin_oe | output | NUM_PINS (54) | Per-pin output-enable |
| card_route_b | output | 1 | Card interface routed to controller B when 1 |

## Verification
Function words are swept with eight arithmetic code patterns across all six words, with the unused top bits forced high. This separates a correct field layout from shifted or overlapping fields, and shows that pins beyond 53 are truncated. The level latches are tried with a walking single bit across all 54 pins and then with pseudo-random set and clear masks on both banks. Together these expose bank mix-ups and OR-versus-overwrite errors. Targeted sequences re-set an already-high pin after switching it to output, and walk the pins 48 to 53 through mixed states. These separate a drive that follows the latch from one gated on a real change, and a sticky selector from one that reacts to every write.

// File: rtl/gfl_pkg.sv
package gfl_pkg;

   typedef enum logic [2:0] {
      FN_IN   = 3'd0,
      FN_OUT  = 3'd1,
      FN_ALT5 = 3'd2,
      FN_ALT4 = 3'd3,
      FN_ALT0 = 3'd4,
      FN_ALT1 = 3'd5,
      FN_ALT2 = 3'd6,
      FN_ALT3 = 3'd7
   } fn_code_e;

   typedef enum logic [2:0] {
      K_NONE,
      K_FUNC,
      K_SET,
      K_CLR,
      K_LEVEL,
      K_EVENT,
      K_PULL
   } reg_kind_e;

   localparam int IDX_W = 6;

   typedef struct packed {
      reg_kind_e          kind;
      logic [IDX_W-1:0]   idx;
   } reg_dec_t;

   // word indices (byte offset / 4) whose positions software depends on
   localparam int W_SET0      = 7;
   localparam int W_CLR0      = 10;
   localparam int W_LEV0      = 13;
   localparam int W_EVT_FIRST = 16;
   localparam int W_EVT_LAST  = 35;
   localparam int W_PULL0     = 57;
   localparam int NUM_PULL    = 4;
   localparam int NUM_LBANKS  = 2;

endpackage

// File: rtl/gfl_decode.sv
module gfl_decode
   import gfl_pkg::*;
#(
   parameter int AW        = 8,
   parameter int NUM_FREGS = 6
) (
   input  logic [AW-1:0] addr,
   output reg_dec_t      dec
);

   localparam int WW = AW - 2;

   logic [WW-1:0] word;
   assign word = addr[AW-1:2];

   always_comb begin
      int wi;
      wi = int'(word);
      dec.kind = K_NONE;
      dec.idx  = '0;
      if (addr[1:0] == 2'b00) begin
         if (wi < NUM_FREGS) begin
            dec.kind = K_FUNC;
            dec.idx  = IDX_W'(wi);
         end else if (wi >= W_SET0 && wi < W_SET0 + NUM_LBANKS) begin
            dec.kind = K_SET;
            dec.idx  = IDX_W'(wi - W_SET0);
         end else if (wi >= W_CLR0 && wi < W_CLR0 + NUM_LBANKS) begin
            dec.kind = K_CLR;
            dec.idx  = IDX_W'(wi - W_CLR0);
         end else if (wi >= W_LEV0 && wi < W_LEV0 + NUM_LBANKS) begin
            dec.kind = K_LEVEL;
            dec.idx  = IDX_W'(wi - W_LEV0);
         end else if (wi >= W_EVT_FIRST && wi <= W_EVT_LAST) begin
            dec.kind = K_EVENT;
         end else if (wi >= W_PULL0 && wi < W_PULL0 + NUM_PULL) begin
            dec.kind = K_PULL;
            dec.idx  = IDX_W'(wi - W_PULL0);
         end
      end
   end

endmodule

// File: rtl/gfl_func_bank.sv
module gfl_func_bank
   import gfl_pkg::*;
#(
   parameter int NUM_PINS  = 54,
   parameter int FC_W      = 3,
   parameter int PER_REG   = 10,
   parameter int NUM_FREGS = 6,
   parameter int DW        = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [IDX_W-1:0]          widx,
   input  logic [IDX_W-1:0]          ridx,
   input  logic [DW-1:0]             wdata,
   output logic [NUM_PINS*FC_W-1:0]  codes,
   output logic [DW-1:0]             rd_word
);

   logic [FC_W-1:0] code_q [NUM_PINS];

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      localparam int REG = p / PER_REG;
      localparam int FLD = p % PER_REG;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            code_q[p] <= '0;
         end else if (we && widx == IDX_W'(REG)) begin
            code_q[p] <= wdata[FLD*FC_W +: FC_W];
         end
      end

      assign codes[p*FC_W +: FC_W] = code_q[p];
   end

   always_comb begin
      rd_word = '0;
      for (int p = 0; p < NUM_PINS; p++) begin
         if (ridx == IDX_W'(p / PER_REG)) begin
            rd_word[(p % PER_REG)*FC_W +: FC_W] = code_q[p];
         end
      end
   end

endmodule

// File: rtl/gfl_level_bank.sv
module gfl_level_bank #(
   parameter int NUM_PINS = 54,
   parameter int DW       = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 set_we,
   input  logic                 clr_we,
   input  logic                 bank_sel,
   input  logic [DW-1:0]        wdata,
   input  logic [NUM_PINS-1:0]  is_out,
   output logic [NUM_PINS-1:0]  level,
   output logic [NUM_PINS-1:0]  drive
);

   logic [NUM_PINS-1:0] mask;
   logic [NUM_PINS-1:0] lev_q;
   logic [NUM_PINS-1:0] lev_d;
   logic [NUM_PINS-1:0] drv_q;
   logic [NUM_PINS-1:0] upd;

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_mask
      localparam int BANK = p / DW;
      localparam int BIT  = p % DW;
      assign mask[p] = (bank_sel == 1'(BANK)) & wdata[BIT];
   end

   always_comb begin
      lev_d = lev_q;
      if (set_we) begin
         lev_d = lev_q | mask;
      end else if (clr_we) begin
         lev_d = lev_q & ~mask;
      end
   end

   // drive follows a real latch change on output-mode pins only
   assign upd = is_out & (lev_d ^ lev_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lev_q <= '0;
         drv_q <= '0;
      end else begin
         lev_q <= lev_d;
         drv_q <= (lev_d & upd) | (drv_q & ~upd);
      end
   end

   assign level = lev_q;
   assign drive = drv_q;

endmodule

// File: rtl/gfl_pull_bank.sv
module gfl_pull_bank
   import gfl_pkg::*;
#(
   parameter int                      NUM_REGS   = 4,
   parameter int                      DW         = 32,
   parameter logic [NUM_REGS*DW-1:0]  RESET_VALS = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [IDX_W-1:0]    widx,
   input  logic [IDX_W-1:0]    ridx,
   input  logic [DW-1:0]       wdata,
   output logic [DW-1:0]       rd_word
);

   logic [DW-1:0] pull_q [NUM_REGS];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pull_q[i] <= RESET_VALS[i*DW +: DW];
         end else if (we && widx == IDX_W'(i)) begin
            pull_q[i] <= wdata;
         end
      end
   end

   always_comb begin
      rd_word = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (ridx == IDX_W'(i)) begin
            rd_word = pull_q[i];
         end
      end
   end

endmodule

// File: rtl/gfl_route_sel.sv
module gfl_route_sel
   import gfl_pkg::*;
#(
   parameter int NUM_PINS = 54,
   parameter int FC_W     = 3,
   parameter int BASE     = 48,
   parameter int CNT      = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_PINS*FC_W-1:0]  codes,
   output logic                      route_b
);

   if (CNT == 0) begin : g_fixed
      assign route_b = 1'b0;
   end else begin : g_sticky
      logic all_in;
      logic all_alt0;
      logic route_q;

      always_comb begin
         all_in   = 1'b1;
         all_alt0 = 1'b1;
         for (int k = 0; k < CNT; k++) begin
            if (codes[(BASE+k)*FC_W +: FC_W] != FC_W'(FN_IN))   all_in   = 1'b0;
            if (codes[(BASE+k)*FC_W +: FC_W] != FC_W'(FN_ALT0)) all_alt0 = 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            route_q <= 1'b0;
         end else if (all_in) begin
            route_q <= 1'b0;
         end else if (all_alt0) begin
            route_q <= 1'b1;
         end
      end

      assign route_b = route_q;
   end

endmodule

// File: rtl/gfl_pin_ctrl.sv
module gfl_pin_ctrl
   import gfl_pkg::*;
#(
   parameter int NUM_PINS   = 54,
   parameter int AW         = 8,
   parameter int DW         = 32,
   parameter int FC_W       = 3,
   parameter int PER_REG    = 10,
   parameter int ROUTE_BASE = 48,
   parameter int ROUTE_CNT  = 6,
   parameter logic [NUM_PULL*DW-1:0] PULL_RESET =
      {32'h0005_5555, 32'h50AA_A95A, 32'hA0AA_AAAA, 32'hAAA9_5555}
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   input  logic [AW-1:0]        bus_addr,
   input  logic [DW-1:0]        bus_wdata,
   output logic [DW-1:0]        bus_rdata,
   output logic                 bus_err,
   output logic [NUM_PINS-1:0]  pin_drive,
   output logic [NUM_PINS-1:0]  pin_oe,
   output logic                 card_route_b
);

   localparam int NUM_FREGS = (NUM_PINS + PER_REG - 1) / PER_REG;

   if (NUM_PINS > NUM_LBANKS * DW) begin : g_chk_pins
      $error("NUM_PINS exceeds the two level banks");
   end
   if (PER_REG * FC_W > DW) begin : g_chk_pack
      $error("function fields do not fit one word");
   end
   if (NUM_FREGS > W_SET0) begin : g_chk_freg
      $error("function words overlap the set ports");
   end
   if (FC_W != 3) begin : g_chk_fcw
      $error("function encoding needs 3-bit codes");
   end
   if (AW < 8) begin : g_chk_aw
      $error("address too narrow for the pull words");
   end
   if (ROUTE_BASE + ROUTE_CNT > NUM_PINS) begin : g_chk_route
      $error("routing pins exceed NUM_PINS");
   end

   reg_dec_t                  dec;
   logic [NUM_PINS*FC_W-1:0]  codes;
   logic [NUM_PINS-1:0]       is_out;
   logic [NUM_PINS-1:0]       level;
   logic [DW-1:0]             func_rd;
   logic [DW-1:0]             pull_rd;
   logic [DW-1:0]             lev_rd;
   logic [DW-1:0]             rd_mux;
   logic [DW-1:0]             rdata_q;
   logic                      err_q;

   gfl_decode #(.AW(AW), .NUM_FREGS(NUM_FREGS)) u_dec (
      .addr (bus_addr),
      .dec  (dec)
   );

   gfl_func_bank #(
      .NUM_PINS(NUM_PINS), .FC_W(FC_W), .PER_REG(PER_REG),
      .NUM_FREGS(NUM_FREGS), .DW(DW)
   ) u_func (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (bus_wr && dec.kind == K_FUNC),
      .widx    (dec.idx),
      .ridx    (dec.idx),
      .wdata   (bus_wdata),
      .codes   (codes),
      .rd_word (func_rd)
   );

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_oe
      assign is_out[p] = (codes[p*FC_W +: FC_W] == FC_W'(FN_OUT));
   end

   gfl_level_bank #(.NUM_PINS(NUM_PINS), .DW(DW)) u_lev (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_we   (bus_wr && dec.kind == K_SET),
      .clr_we   (bus_wr && dec.kind == K_CLR),
      .bank_sel (dec.idx[0]),
      .wdata    (bus_wdata),
      .is_out   (is_out),
      .level    (level),
      .drive    (pin_drive)
   );

   gfl_pull_bank #(.NUM_REGS(NUM_PULL), .DW(DW), .RESET_VALS(PULL_RESET)) u_pull (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (bus_wr && dec.kind == K_PULL),
      .widx    (dec.idx),
      .ridx    (dec.idx),
      .wdata   (bus_wdata),
      .rd_word (pull_rd)
   );

   gfl_route_sel #(
      .NUM_PINS(NUM_PINS), .FC_W(FC_W), .BASE(ROUTE_BASE), .CNT(ROUTE_CNT)
   ) u_route (
      .clk     (clk),
      .rst_n   (rst_n),
      .codes   (codes),
      .route_b (card_route_b)
   );

   always_comb begin
      lev_rd = '0;
      for (int p = 0; p < NUM_PINS; p++) begin
         if (dec.idx[0] == 1'(p / DW)) begin
            lev_rd[p % DW] = level[p];
         end
      end
   end

   always_comb begin
      case (dec.kind)
         K_FUNC:  rd_mux = func_rd;
         K_LEVEL: rd_mux = lev_rd;
         K_PULL:  rd_mux = pull_rd;
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q <= '0;
         err_q   <= 1'b0;
      end else begin
         rdata_q <= bus_rd ? rd_mux : '0;
         err_q   <= (bus_rd || bus_wr) && dec.kind == K_NONE;
      end
   end

   assign bus_rdata = rdata_q;
   assign bus_err   = err_q;
   assign pin_oe    = is_out;

endmodule

// File: rtl/gfl_pin_ctrl_chk.sv
module gfl_pin_ctrl_chk #(
   parameter int NUM_PINS = 54,
   parameter int DW       = 32
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_wr,
   input logic                 bus_rd,
   input logic [DW-1:0]        bus_rdata,
   input logic                 bus_err,
   input logic [NUM_PINS-1:0]  pin_drive,
   input logic [NUM_PINS-1:0]  pin_oe,
   input logic                 card_route_b
);

   // R10: an error flag needs an access in the previous cycle
   a_r10_err_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr || bus_rd) |=> !bus_err);

   // R11: read data is zero unless a read was sampled
   a_r11_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> bus_rdata == '0);

   // R2: output-enables move only after a write
   a_r2_oe_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(pin_oe));

   // R6: drive values hold without a write
   a_r6_drive_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(pin_drive));

   // R6: a drive bit may only move on a pin that was in output mode
   a_r6_drive_only_out: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |=> ((pin_drive ^ $past(pin_drive)) & ~$past(pin_oe)) == '0);

   // R8: routing moves only on the edge after a stored write
   a_r8_route_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr && !$past(bus_wr)) |=> $stable(card_route_b));

endmodule

bind gfl_pin_ctrl gfl_pin_ctrl_chk #(.NUM_PINS(NUM_PINS), .DW(DW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_wr       (bus_wr),
   .bus_rd       (bus_rd),
   .bus_rdata    (bus_rdata),
   .bus_err      (bus_err),
   .pin_drive    (pin_drive),
   .pin_oe       (pin_oe),
   .card_route_b (card_route_b)
);

// File: tb/gfl_pin_ctrl_test.sv
module gfl_pin_ctrl_test;

   localparam int NP = 54;
   localparam int AW = 8;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          bus_err;
   logic [NP-1:0] pin_drive;
   logic [NP-1:0] pin_oe;
   logic          card_route_b;

   gfl_pin_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_err(bus_err), .pin_drive(pin_drive), .pin_oe(pin_oe),
      .card_route_b(card_route_b)
   );

   always #10 clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   int            mcode [NP];
   logic [NP-1:0] mlev = '0;
   logic [NP-1:0] mdrv = '0;

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, output logic e);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      e = bus_err;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic e);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata; e = bus_err;
   endtask

   function automatic logic [DW-1:0] exp_func(input int r);
      logic [DW-1:0] v = '0;
      for (int i = 0; i < 10; i++) begin
         if (r*10 + i < NP) v |= DW'(mcode[r*10+i] & 7) << (3*i);
      end
      return v;
   endfunction

   function automatic logic [NP-1:0] exp_oe();
      logic [NP-1:0] v = '0;
      for (int p = 0; p < NP; p++) v[p] = (mcode[p] == 1);
      return v;
   endfunction

   function automatic logic [DW-1:0] exp_lev(input int b);
      logic [DW-1:0] v = '0;
      for (int i = 0; i < DW; i++) if (b*DW + i < NP) v[i] = mlev[b*DW+i];
      return v;
   endfunction

   task automatic do_func(input int r, input logic [DW-1:0] d);
      logic e;
      wr(AW'(4*r), d, e);
      for (int i = 0; i < 10; i++) if (r*10 + i < NP) mcode[r*10+i] = int'((d >> (3*i)) & 7);
      chk("R1 func write err", 64'(e), 64'd0);
   endtask

   task automatic do_lvl(input bit is_set, input int b, input logic [DW-1:0] d);
      logic e;
      wr(AW'(is_set ? (8'h1C + 4*b) : (8'h28 + 4*b)), d, e);
      for (int i = 0; i < DW; i++) begin
         if (b*DW + i < NP && d[i]) begin
            if (mcode[b*DW+i] == 1 && mlev[b*DW+i] != is_set) mdrv[b*DW+i] = is_set;
            mlev[b*DW+i] = is_set;
         end
      end
      chk("R3 level write err", 64'(e), 64'd0);
   endtask

   task automatic verify_all();
      logic [DW-1:0] d;
      logic e;
      for (int r = 0; r < 6; r++) begin
         rd(AW'(4*r), d, e);
         chk("R1 func readback", 64'(d), 64'(exp_func(r)));
      end
      for (int b = 0; b < 2; b++) begin
         rd(AW'(8'h34 + 4*b), d, e);
         chk("R3 level readback", 64'(d), 64'(exp_lev(b)));
      end
      chk("R2 output enables", 64'(pin_oe), 64'(exp_oe()));
      chk("R6 drive values", 64'(pin_drive), 64'(mdrv));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [DW-1:0] d;
      logic [DW-1:0] x;
      logic e;
      logic [31:0] pull_rst [4];
      pull_rst[0] = 32'hAAA9_5555; pull_rst[1] = 32'hA0AA_AAAA;
      pull_rst[2] = 32'h50AA_A95A; pull_rst[3] = 32'h0005_5555;
      for (int p = 0; p < NP; p++) mcode[p] = 0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R12 reset state
      @(negedge clk);
      chk("R12 rdata after reset", 64'(bus_rdata), 64'd0);
      chk("R12 err after reset", 64'(bus_err), 64'd0);
      chk("R12 route after reset", 64'(card_route_b), 64'd0);
      chk("R12 oe after reset", 64'(pin_oe), 64'd0);
      chk("R12 drive after reset", 64'(pin_drive), 64'd0);
      verify_all();
      for (int i = 0; i < 4; i++) begin
         rd(AW'(8'hE4 + 4*i), d, e);
         chk("R7 pull reset value", 64'(d), 64'(pull_rst[i]));
      end

      // R1 / R2 sweep of packing patterns, top bits forced high
      for (int s = 0; s < 8; s++) begin
         for (int r = 0; r < 6; r++) begin
            d = 32'hC000_0000;
            for (int i = 0; i < 10; i++) d |= DW'((i*5 + r*3 + s) % 8) << (3*i);
            do_func(r, d);
         end
         verify_all();
      end
      do_func(5, 32'hFFFF_FFFF);
      rd(8'h14, d, e);
      chk("R1 truncated word", 64'(d), 64'h0000_0FFF);

      // mode mix: even pins of word 0, all of words 3 and 5 are outputs
      d = '0;
      for (int i = 0; i < 10; i += 2) d |= DW'(1) << (3*i);
      do_func(0, d);
      for (int r = 1; r < 6; r++) do_func(r, (r == 3 || r == 5) ? 32'h0924_9249 : 32'h0);
      verify_all();

      // R3 walking single bit
      for (int p = 0; p < NP; p++) begin
         do_lvl(1'b1, p / 32, DW'(1) << (p % 32));
         rd(AW'(8'h34 + 4*(p/32)), d, e);
         chk("R3 walking set", 64'(d), 64'(exp_lev(p/32)));
         do_lvl(1'b0, p / 32, DW'(1) << (p % 32));
         rd(AW'(8'h34 + 4*(p/32)), d, e);
         chk("R3 walking clear", 64'(d), 64'(exp_lev(p/32)));
      end
      chk("R6 drive after walk", 64'(pin_drive), 64'(mdrv));

      // R3 / R6 pseudo-random masks
      x = 32'h1234_5678;
      for (int k = 0; k < 24; k++) begin
         x = x * 32'd1103515245 + 32'd12345;
         do_lvl(1'b1, k % 2, x);
         x = x * 32'd1103515245 + 32'd12345;
         do_lvl(1'b0, (k / 2) % 2, x & (x >> 7));
         verify_all();
      end

      // R4 set/clear read zero
      for (int i = 0; i < 4; i++) begin
         rd(AW'((i < 2) ? (8'h1C + 4*i) : (8'h28 + 4*(i-2))), d, e);
         chk("R4 write-only reads zero", 64'(d), 64'd0);
      end

      // R5 level writes ignored
      wr(8'h34, 32'hFFFF_FFFF, e);
      chk("R5 level write err", 64'(e), 64'd0);
      wr(8'h38, 32'h0, e);
      verify_all();

      // R6 targeted: re-set an already-high pin after switching to output
      do_func(1, 32'h0);
      do_lvl(1'b0, 0, 32'hFFFF_FFFF);
      do_lvl(1'b1, 0, 32'h0000_1000);
      chk("R6 input pin no drive", 64'(pin_drive[12]), 64'd0);
      do_func(1, 32'h0000_0040);
      do_lvl(1'b1, 0, 32'h0000_1000);
      chk("R6 unchanged level no drive", 64'(pin_drive[12]), 64'd0);
      do_lvl(1'b0, 0, 32'h0000_1000);
      do_lvl(1'b1, 0, 32'h0000_1000);
      chk("R6 real change drives", 64'(pin_drive[12]), 64'd1);
      verify_all();

      // R8 routing hysteresis
      do_func(4, 32'h2400_0000);
      @(negedge clk);
      chk("R8 partial alt0 holds A", 64'(card_route_b), 64'd0);
      do_func(5, 32'h0000_0924);
      @(negedge clk);
      chk("R8 all alt0 selects B", 64'(card_route_b), 64'd1);
      do_func(5, 32'h0000_0921);
      @(negedge clk);
      chk("R8 mixed holds B", 64'(card_route_b), 64'd1);
      do_func(4, 32'h0);
      @(negedge clk);
      chk("R8 still mixed holds B", 64'(card_route_b), 64'd1);
      do_func(5, 32'h0);
      @(negedge clk);
      chk("R8 all input selects A", 64'(card_route_b), 64'd0);

      // R9 event range
      for (int i = 0; i < 3; i++) begin
         logic [AW-1:0] a;
         a = (i == 0) ? 8'h40 : (i == 1) ? 8'h64 : 8'h8C;
         wr(a, 32'hFFFF_FFFF, e);
         chk("R9 event write err", 64'(e), 64'd0);
         rd(a, d, e);
         chk("R9 event reads zero", 64'(d), 64'd0);
         chk("R9 event read err", 64'(e), 64'd0);
      end
      verify_all();

      // R10 unmapped
      for (int i = 0; i < 4; i++) begin
         logic [AW-1:0] a;
         a = (i == 0) ? 8'h18 : (i == 1) ? 8'h90 : (i == 2) ? 8'hF4 : 8'h01;
         rd(a, d, e);
         chk("R10 unmapped reads zero", 64'(d), 64'd0);
         chk("R10 unmapped read err", 64'(e), 64'd1);
         @(negedge clk);
         chk("R10 err lasts one cycle", 64'(bus_err), 64'd0);
         wr(a, 32'hFFFF_FFFF, e);
         chk("R10 unmapped write err", 64'(e), 64'd1);
      end
      wr(8'h1D, 32'hFFFF_FFFF, e);
      chk("R10 misaligned set err", 64'(e), 64'd1);
      verify_all();

      // R7 pull words read/write
      for (int i = 0; i < 4; i++) wr(AW'(8'hE4 + 4*i), 32'h1111_0000 * (i+1) + 32'h55, e);
      for (int i = 0; i < 4; i++) begin
         rd(AW'(8'hE4 + 4*i), d, e);
         chk("R7 pull readback", 64'(d), 64'(32'h1111_0000 * (i+1) + 32'h55));
      end

      // R11 rdata returns to zero after the read
      rd(8'hE4, d, e);
      @(negedge clk);
      chk("R11 rdata zero when idle", 64'(bus_rdata), 64'd0);

      summary();
   end

endmodule